// File: doc/BRIEF.md
# Conversion Timing Sequencer

This block paces the conversions of a delta-sigma converter by counting master clock cycles. A host asks for a conversion by pulling an active-low request line low. The request passes through a synchronizer. The block then opens a fixed-length conversion window, and at the end of that window it drops an active-low ready flag. In the same cycle it pulses a result strobe and captures the filter's output word. The captured word is coded by the bipolar/unipolar selection that was taken when the conversion started.

The block also times two start-up waits: one after the reset input is released, and one after the sleep input leaves its low-power level. The spacing between conversions depends on how the request line is driven. If the line is held low, conversions follow each other without a gap. If the ready flag is looped back onto the request line, the synchronizer delay adds two cycles to each period. The modulator, the filter arithmetic and the analog power control are outside the block; the filter result arrives as an input word.

Top module: `cts_conv_seq`

## Requirements
- R1: While `rst_n` is low, `rdy_n_o` is high and `strobe_o` is low. After release, `rdy_n_o` falls on the 1536th rising edge of `mclk`, counting the first edge that samples `rst_n` high as edge 1.
- R2: A conversion starts on the second rising edge after the edge that first samples `conv_n` low while idle. `rdy_n_o` returns high at that start.
- R3: `rdy_n_o` falls 319 edges after the start edge, which is well inside 324 cycles.
- R4: While `conv_n` is held low, `rdy_n_o` falls every 320 cycles.
- R5: When `rdy_n_o` is wired back to `conv_n`, `rdy_n_o` falls every 322 cycles.
- R6: A low pulse of 4 cycles on `conv_n` starts a conversion. A request made while a conversion is running is ignored and does not cause a further conversion.
- R7: `bipolar_i` is captured into `mode_o` at the start edge. Changes to `bipolar_i` during a conversion affect neither `mode_o` nor the coding of the result.
- R8: At the end of a conversion, `result_o` takes `filt_word_i` unchanged when `mode_o` is 1 (bipolar, two's complement). When `mode_o` is 0 (unipolar), `result_o` takes `filt_word_i` plus 2^(WORD_W-1) modulo 2^WORD_W, which is offset binary.
- R9: While `sleep_n` is low, `rdy_n_o` stays high, no strobe is produced, and requests are ignored.
- R10: After `sleep_n` returns high, `rdy_n_o` falls on the 3083rd edge, counting the first edge that samples it high as edge 1. No strobe is produced at that point.
- R11: `strobe_o` is a one-cycle pulse that occurs only together with the `rdy_n_o` fall at the end of a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset; clears all counters |
| conv_n | input | 1 | Active-low conversion request, asynchronous |
| sleep_n | input | 1 | Low selects the low-power state |
| bipolar_i | input | 1 | 1 = bipolar coding, 0 = unipolar coding |
| filt_word_i | input | WORD_W | Filter result word in two's complement |
| rdy_n_o | output | 1 | Active-low ready flag |
| mode_o | output | 1 | Coding mode latched at the conversion start |
| strobe_o | output | 1 | One-cycle pulse when a result is captured |
| result_o | output | WORD_W | Captured and coded result |

## Verification
The bench measures three different periods to the exact edge: a single request, a request line held low, and a ready flag looped back. A design that mis-counted the synchronizer stages or started from the request edge rather than the synced level would be off by one or two cycles in at least one of these. It changes the mode input in the middle of a conversion and injects a request while busy. A design that sampled the mode late, or that latched a pending request, would produce a wrongly coded word or an extra unplanned strobe, and the scoreboard would see it. It also checks both start-up waits at their last quiet edge and at their fall, and it checks that sleep suppresses any request.

// File: rtl/cts_pkg.sv
package cts_pkg;

  typedef enum logic [2:0] {
    PH_PWRUP = 3'd0,
    PH_IDLE  = 3'd1,
    PH_BUSY  = 3'd2,
    PH_SLEEP = 3'd3,
    PH_WAKE  = 3'd4
  } phase_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;

  // idle level of the request line is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/cts_result.sv
module cts_result #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         done_i,
  input  logic         bipolar_i,
  input  logic [W-1:0] word_i,
  output logic         mode_o,
  output logic         strobe_o,
  output logic [W-1:0] result_o
);

  localparam int MSB = W - 1;

  // bipolar keeps two's complement, unipolar flips the sign bit
  function automatic logic [W-1:0] code_map(input logic [W-1:0] w, input logic bip);
    logic [W-1:0] r;
    r = w;
    if (!bip) r[MSB] = ~w[MSB];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o   <= 1'b0;
      strobe_o <= 1'b0;
      result_o <= '0;
    end else begin
      strobe_o <= done_i;
      if (start_i) mode_o <= bipolar_i;
      if (done_i)  result_o <= code_map(word_i, mode_o);
    end
  end

  // R11
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);

  // R8
  code_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> result_o[MSB-1:0] == $past(word_i[MSB-1:0]));

  // R8
  code_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> result_o[MSB] == ($past(word_i[MSB]) ^ !mode_o));

endmodule

// File: rtl/cts_conv_seq.sv
module cts_conv_seq #(
  parameter int WORD_W      = 24,
  parameter int RST_CYC     = 1536,
  parameter int WAKE_CYC    = 3083,
  parameter int CONV_PERIOD = 320,
  parameter int SYNC_STAGES = 2
) (
  input  logic              mclk,
  input  logic              rst_n,
  input  logic              conv_n,
  input  logic              sleep_n,
  input  logic              bipolar_i,
  input  logic [WORD_W-1:0] filt_word_i,
  output logic              rdy_n_o,
  output logic              mode_o,
  output logic              strobe_o,
  output logic [WORD_W-1:0] result_o
);
  import cts_pkg::*;

  localparam int MAXL      = max3(RST_CYC, WAKE_CYC, CONV_PERIOD);
  localparam int CW        = $clog2(MAXL + 1);
  localparam int RST_LAST  = RST_CYC - 1;
  localparam int WAKE_LAST = WAKE_CYC - 1;
  // one idle edge between back-to-back conversions completes the period
  localparam int BUSY_LAST = CONV_PERIOD - 2;

  phase_t        ph_q;
  logic [CW-1:0] cnt_q;
  logic          rdy_q;
  logic          req_n;
  logic          start_evt;
  logic          conv_done;
  logic          ramp_done;

  cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (mclk),
    .rst_n(rst_n),
    .d_i  (conv_n),
    .q_o  (req_n)
  );

  assign start_evt = (ph_q == PH_IDLE) && sleep_n && !req_n;
  assign conv_done = (ph_q == PH_BUSY) && sleep_n && (cnt_q == CW'(BUSY_LAST));
  assign ramp_done = sleep_n &&
                     (((ph_q == PH_PWRUP) && (cnt_q == CW'(RST_LAST))) ||
                      ((ph_q == PH_WAKE)  && (cnt_q == CW'(WAKE_LAST))));

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_PWRUP;
      cnt_q <= '0;
      rdy_q <= 1'b1;
    end else if (!sleep_n) begin
      ph_q  <= PH_SLEEP;
      cnt_q <= '0;
      rdy_q <= 1'b1;
    end else begin
      case (ph_q)
        PH_PWRUP, PH_WAKE: begin
          if (ramp_done) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            rdy_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_SLEEP: begin
          ph_q  <= PH_WAKE;
          cnt_q <= CW'(1);
        end
        PH_IDLE: begin
          if (start_evt) begin
            ph_q  <= PH_BUSY;
            cnt_q <= '0;
            rdy_q <= 1'b1;
          end
        end
        PH_BUSY: begin
          if (conv_done) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            rdy_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign rdy_n_o = rdy_q;

  cts_result #(.W(WORD_W)) u_result (
    .clk      (mclk),
    .rst_n    (rst_n),
    .start_i  (start_evt),
    .done_i   (conv_done),
    .bipolar_i(bipolar_i),
    .word_i   (filt_word_i),
    .mode_o   (mode_o),
    .strobe_o (strobe_o),
    .result_o (result_o)
  );

  // R1
  rst_hold_chk: assert property (@(posedge mclk)
    !rst_n |=> (rdy_n_o && !strobe_o));

  // R2
  start_rise_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    start_evt |=> rdy_n_o);

  // R3
  busy_bound_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (ph_q == PH_BUSY) |-> (cnt_q <= CW'(BUSY_LAST)));

  // R7
  mode_hold_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (ph_q == PH_BUSY) |=> $stable(mode_o));

  // R9
  sleep_quiet_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !sleep_n |=> (rdy_n_o && !strobe_o));

  // R11
  strobe_rdy_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    strobe_o |-> !rdy_n_o);

endmodule

// File: tb/cts_conv_seq_tb.sv
module cts_conv_seq_tb;

  localparam int W    = 24;
  localparam int RSTC = 1536;
  localparam int WAKC = 3083;
  localparam int PER  = 320;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         conv_drv = 1'b1;
  logic         tie = 1'b0;
  logic         sleep_n = 1'b1;
  logic         bipolar = 1'b1;
  logic [W-1:0] filt = '0;
  logic         conv_n_w;
  logic         rdy_n;
  logic         mode;
  logic         strobe;
  logic [W-1:0] result;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [W:0] exp_q[$];

  always #2 clk = ~clk;

  assign conv_n_w = tie ? rdy_n : conv_drv;

  cts_conv_seq #(
    .WORD_W(W), .RST_CYC(RSTC), .WAKE_CYC(WAKC), .CONV_PERIOD(PER), .SYNC_STAGES(2)
  ) u_dut (
    .mclk(clk), .rst_n(rst_n), .conv_n(conv_n_w), .sleep_n(sleep_n),
    .bipolar_i(bipolar), .filt_word_i(filt),
    .rdy_n_o(rdy_n), .mode_o(mode), .strobe_o(strobe), .result_o(result)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side of the scoreboard: offset binary is the word shifted by half range
  task automatic push_exp(input logic bip, input logic [W-1:0] w);
    logic [W-1:0] e;
    e = bip ? w : W'(w + (W'(1) << (W - 1)));
    exp_q.push_back({bip, e});
  endtask

  // monitor side: every strobe must match the oldest expectation (R8, R11)
  always @(negedge clk) begin
    if (rst_n && strobe) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11", "unexpected strobe", 32'(result), 32'h0);
      end else begin
        logic [W:0] e;
        e = exp_q.pop_front();
        chk(result == e[W-1:0], "R8", "result", 32'(result), 32'(e[W-1:0]));
        chk(mode == e[W], "R7", "mode at strobe", 32'(mode), 32'(e[W]));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", "run hung", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state and power-up wait
    tick(3);
    chk(rdy_n == 1'b1, "R1", "rdy_n in reset", 32'(rdy_n), 32'h1);
    chk(strobe == 1'b0, "R1", "strobe in reset", 32'(strobe), 32'h0);
    rst_n = 1'b1;
    tick(RSTC - 1);
    chk(rdy_n == 1'b1, "R1", "rdy_n before power-up end", 32'(rdy_n), 32'h1);
    tick(1);
    chk(rdy_n == 1'b0, "R1", "rdy_n at power-up end", 32'(rdy_n), 32'h0);

    // single 4-cycle request, bipolar, mode changed mid-conversion
    bipolar = 1'b1;
    filt = 24'h123456;
    push_exp(1'b1, 24'h123456);
    conv_drv = 1'b0;
    tick(2);
    chk(rdy_n == 1'b0, "R2", "rdy_n before start", 32'(rdy_n), 32'h0);
    tick(1);
    chk(rdy_n == 1'b1, "R2", "rdy_n at start", 32'(rdy_n), 32'h1);
    tick(1);
    conv_drv = 1'b1;   // R6: pulse covered four edges
    bipolar = 1'b0;    // R7: must not take effect
    tick(96);
    conv_drv = 1'b0;   // R6: request while busy
    tick(5);
    conv_drv = 1'b1;
    chk(mode == 1'b1, "R7", "mode mid-conversion", 32'(mode), 32'h1);
    tick(216);
    chk(rdy_n == 1'b1, "R3", "rdy_n one edge before end", 32'(rdy_n), 32'h1);
    tick(1);
    chk(rdy_n == 1'b0, "R3", "rdy_n at end", 32'(rdy_n), 32'h0);
    chk(strobe == 1'b1, "R11", "strobe at end", 32'(strobe), 32'h1);
    tick(1);
    chk(strobe == 1'b0, "R11", "strobe one cycle", 32'(strobe), 32'h0);
    tick(20);
    chk(rdy_n == 1'b0, "R6", "no conversion from busy request", 32'(rdy_n), 32'h0);

    // R4: held low, unipolar
    bipolar = 1'b0;
    filt = 24'h800001;
    push_exp(1'b0, 24'h800001);
    conv_drv = 1'b0;
    tick(321);
    chk(rdy_n == 1'b1, "R4", "first busy", 32'(rdy_n), 32'h1);
    tick(1);
    chk(rdy_n == 1'b0, "R4", "first ready", 32'(rdy_n), 32'h0);
    filt = 24'h7FFFFF;
    push_exp(1'b0, 24'h7FFFFF);
    tick(PER - 1);
    chk(rdy_n == 1'b1, "R4", "second busy", 32'(rdy_n), 32'h1);
    tick(1);
    chk(rdy_n == 1'b0, "R4", "second ready at 320", 32'(rdy_n), 32'h0);
    filt = 24'h000000;
    push_exp(1'b0, 24'h000000);
    tick(100);
    conv_drv = 1'b1;
    tick(PER - 101);
    chk(rdy_n == 1'b1, "R4", "third busy", 32'(rdy_n), 32'h1);
    tick(1);
    chk(rdy_n == 1'b0, "R4", "third ready at 320", 32'(rdy_n), 32'h0);
    tick(10);
    chk(rdy_n == 1'b0, "R4", "stopped after release", 32'(rdy_n), 32'h0);

    // R5: ready looped back onto the request
    bipolar = 1'b1;
    filt = 24'hFFFFFF;
    push_exp(1'b1, 24'hFFFFFF);
    push_exp(1'b1, 24'hFFFFFF);
    tie = 1'b1;
    tick(321);
    chk(rdy_n == 1'b1, "R5", "loop first busy", 32'(rdy_n), 32'h1);
    tick(1);
    chk(rdy_n == 1'b0, "R5", "loop first ready", 32'(rdy_n), 32'h0);
    tick(321);
    chk(rdy_n == 1'b1, "R5", "loop busy at 321", 32'(rdy_n), 32'h1);
    tick(1);
    chk(rdy_n == 1'b0, "R5", "loop ready at 322", 32'(rdy_n), 32'h0);
    tie = 1'b0;
    conv_drv = 1'b1;
    tick(10);
    chk(rdy_n == 1'b0, "R5", "loop opened", 32'(rdy_n), 32'h0);

    // R9 / R10: sleep and wake
    sleep_n = 1'b0;
    tick(1);
    chk(rdy_n == 1'b1, "R9", "rdy_n in sleep", 32'(rdy_n), 32'h1);
    conv_drv = 1'b0;
    tick(20);
    chk(rdy_n == 1'b1, "R9", "request ignored in sleep", 32'(rdy_n), 32'h1);
    conv_drv = 1'b1;
    tick(3);
    sleep_n = 1'b1;
    tick(WAKC - 1);
    chk(rdy_n == 1'b1, "R10", "rdy_n before wake end", 32'(rdy_n), 32'h1);
    tick(1);
    chk(rdy_n == 1'b0, "R10", "rdy_n at wake end", 32'(rdy_n), 32'h0);
    chk(strobe == 1'b0, "R10", "no strobe on wake", 32'(strobe), 32'h0);
    tick(5);

    chk(exp_q.size() == 0, "R11", "pending expectations", 32'(exp_q.size()), 32'h0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule